// File: doc/BRIEF.md
# Block-Aligned DMA Transfer Splitter

This block takes one DMA transfer at a time and turns it into a series of sub-requests. A transfer is described by a start byte address, a byte length and a direction. No sub-request crosses the boundary of a cache block. The first piece may begin partway into a block and runs at most to that block's end. Every piece after it starts on a block boundary and covers a whole block, or whatever remains of the transfer if that is less.

Only one sub-request is in flight at any time. The next piece goes out only after the current one has been answered: an acknowledge for a write, or a returned data block for a read. Write bytes come from a local byte buffer indexed from the start of the transfer, and they are placed on the byte lanes that match their addresses inside the block. Read data arriving from the matching lanes is packed into the same buffer at the transfer-relative position. When the last piece has been answered, a one-cycle done pulse carries the identifier that was handed out when the transfer was accepted.

Top module: `dma_block_splitter`

## Requirements
- R1: A request is accepted (`req_accept` high in the same cycle as `req_valid`) only when the block is idle, the kind is plain read (`2'b00`) or plain write (`2'b01`), and the length lies in 1..BUF_BYTES. Any other request is refused (`req_refuse` high, `req_accept` low). This covers kinds `2'b10` (fetch) and `2'b11` (locked), a zero length, an oversize length, and any request made while busy.
- R2: `req_id` shows the identifier the next accepted request will get. It is 0 after reset, rises by one (modulo 2^ID_W) on each acceptance, and does not change on a refusal.
- R3: The first sub-request has `sub_addr` equal to the start address and `sub_off` equal to the start address modulo BLK_BYTES. Its `sub_len` is the smaller of the length and BLK_BYTES minus that offset.
- R4: Every later sub-request has `sub_addr` equal to the start address plus the bytes already completed, and `sub_off` equal to 0, so the address is block-aligned. Its `sub_len` is the smaller of the remaining bytes and BLK_BYTES.
- R5: At most one sub-request is outstanding. `sub_valid` stays high with stable fields until `sub_ready`. It then drops and stays low until a response arrives, and the next piece appears on the cycle after that response. A response given while no sub-request is awaiting one has no effect.
- R6: For a write, `sub_be` bit j is set exactly for lanes `sub_off <= j < sub_off+sub_len`. Byte lane j of `sub_wdata` carries buffer byte `completed + j - sub_off`, and disabled lanes carry zero.
- R7: For a read, on each response, lanes `sub_off..sub_off+sub_len-1` of `rsp_data` are stored at buffer bytes `completed..completed+sub_len-1`. After the transfer, buffer byte k holds the memory byte at start+k.
- R8: In the cycle after the clock edge that takes the final response, `done_valid` is high for exactly one cycle with `done_id` equal to the accepted identifier, and `busy` is already low.
- R9: After reset, `busy`, `sub_valid` and `done_valid` are low and `req_id` is 0.
- R10: `busy` is high from the cycle after acceptance until completion, and `sub_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch (illegal), 11 locked (illegal) |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_accept | output | 1 | Request taken this cycle |
| req_refuse | output | 1 | Request refused this cycle |
| req_id | output | ID_W | Identifier given to the next accepted request |
| busy | output | 1 | A transfer is active |
| sub_valid | output | 1 | Sub-request offered |
| sub_ready | input | 1 | Sub-request taken by memory side |
| sub_addr | output | ADDR_W | Sub-request byte address |
| sub_off | output | OFF_W | Offset inside the block |
| sub_len | output | SUBLEN_W | Sub-request length in bytes |
| sub_write | output | 1 | 1 for write, 0 for read |
| sub_wdata | output | BLK_BYTES*8 | Block-wide write data, lane j is block byte j |
| sub_be | output | BLK_BYTES | Per-lane byte enables |
| rsp_valid | input | 1 | Acknowledge or data return for the outstanding sub-request |
| rsp_data | input | BLK_BYTES*8 | Returned block data for reads |
| done_valid | output | 1 | Transfer complete pulse |
| done_id | output | ID_W | Identifier of the completed transfer |
| buf_we | input | 1 | Local buffer byte write |
| buf_waddr | input | IDX_W | Local buffer write index |
| buf_wdata | input | 8 | Local buffer write byte |
| buf_raddr | input | IDX_W | Local buffer read index |
| buf_rdata | output | 8 | Local buffer read byte (combinational) |

## Verification
A wrong byte count shows on the next sub-request to leave the block. It appears as a length that runs past the block end, a misaligned address, or a done pulse that comes one piece early or late, all within a handshake of the fault. A wrong lane or buffer offset appears in `sub_wdata`/`sub_be` on that same piece for writes, but for reads it stays hidden until the buffer is read back after done. For that reason every read transfer is followed by a full readback. Sweeping every start offset in a block against lengths from one byte to well past two blocks reaches each split shape: partial-only, partial-plus-full, and partial tails.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  typedef enum logic [1:0] {
    KIND_READ   = 2'b00,
    KIND_WRITE  = 2'b01,
    KIND_FETCH  = 2'b10,
    KIND_LOCKED = 2'b11
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } split_state_e;

endpackage

// File: rtl/dma_split_rst_sync.sv
module dma_split_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dma_split_ctrl.sv
module dma_split_ctrl
  import dma_split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int BUF_BYTES = 256,
  parameter int ID_W      = 8,
  parameter int LEN_W     = 9,
  parameter int OFF_W     = 6,
  parameter int SUBLEN_W  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  output logic                req_accept,
  output logic                req_refuse,
  output logic [ID_W-1:0]     req_id,
  output logic                busy,
  output logic                sub_valid,
  input  logic                sub_ready,
  output logic [ADDR_W-1:0]   sub_addr,
  output logic [OFF_W-1:0]    sub_off,
  output logic [SUBLEN_W-1:0] sub_len,
  output logic                sub_write,
  input  logic                rsp_valid,
  output logic                rd_capture,
  output logic [LEN_W-1:0]    completed,
  output logic                done_valid,
  output logic [ID_W-1:0]     done_id
);

  localparam int CW = ((LEN_W > SUBLEN_W) ? LEN_W : SUBLEN_W) + 1;

  split_state_e          st_q, st_d;
  logic [ADDR_W-1:0]     start_q, start_d, saddr_q, saddr_d;
  logic [LEN_W-1:0]      total_q, total_d, issued_q, issued_d, compl_q, compl_d;
  logic [OFF_W-1:0]      off_q, off_d;
  logic [SUBLEN_W-1:0]   slen_q, slen_d;
  logic                  wr_q, wr_d, done_q, done_d;
  logic [ID_W-1:0]       id_q, id_d, nid_q, nid_d;

  logic                  kind_ok, len_ok, accept, rsp_take, upd;
  logic [OFF_W-1:0]      first_off;
  logic [CW-1:0]         room, first_len_w, remain_w, next_len_w;

  // request legality and piece sizing
  always_comb begin
    kind_ok     = (req_kind == KIND_READ) || (req_kind == KIND_WRITE);
    len_ok      = (req_len != '0) && (CW'(req_len) <= CW'(BUF_BYTES));
    accept      = req_valid && kind_ok && len_ok && (st_q == ST_IDLE);
    rsp_take    = (st_q == ST_WAIT) && rsp_valid;
    upd         = accept || rsp_take;
    first_off   = req_addr[OFF_W-1:0];
    room        = CW'(BLK_BYTES) - CW'(first_off);
    first_len_w = (CW'(req_len) < room) ? CW'(req_len) : room;
    remain_w    = CW'(total_q) - CW'(issued_q);
    next_len_w  = (remain_w < CW'(BLK_BYTES)) ? remain_w : CW'(BLK_BYTES);
  end

  // next state
  always_comb begin
    st_d     = st_q;
    start_d  = start_q;
    saddr_d  = saddr_q;
    total_d  = total_q;
    issued_d = issued_q;
    compl_d  = compl_q;
    off_d    = off_q;
    slen_d   = slen_q;
    wr_d     = wr_q;
    id_d     = id_q;
    nid_d    = nid_q;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          start_d  = req_addr;
          saddr_d  = req_addr;
          total_d  = req_len;
          wr_d     = (req_kind == KIND_WRITE);
          id_d     = nid_q;
          nid_d    = nid_q + ID_W'(1);
          off_d    = first_off;
          slen_d   = SUBLEN_W'(first_len_w);
          issued_d = LEN_W'(first_len_w);
          compl_d  = '0;
          st_d     = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (sub_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          compl_d = issued_q;
          if (issued_q == total_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            saddr_d  = start_q + ADDR_W'(issued_q);
            off_d    = '0;
            slen_d   = SUBLEN_W'(next_len_w);
            issued_d = issued_q + LEN_W'(next_len_w);
            st_d     = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done_q   <= 1'b0;
      start_q  <= '0;
      saddr_q  <= '0;
      total_q  <= '0;
      issued_q <= '0;
      compl_q  <= '0;
      off_q    <= '0;
      slen_q   <= '0;
      wr_q     <= 1'b0;
      id_q     <= '0;
      nid_q    <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (upd) begin
        start_q  <= start_d;
        saddr_q  <= saddr_d;
        total_q  <= total_d;
        issued_q <= issued_d;
        compl_q  <= compl_d;
        off_q    <= off_d;
        slen_q   <= slen_d;
        wr_q     <= wr_d;
        id_q     <= id_d;
        nid_q    <= nid_d;
      end
    end
  end

  assign req_accept = accept;
  assign req_refuse = req_valid && !accept;
  assign req_id     = nid_q;
  assign busy       = (st_q != ST_IDLE);
  assign sub_valid  = (st_q == ST_ISSUE);
  assign sub_addr   = saddr_q;
  assign sub_off    = off_q;
  assign sub_len    = slen_q;
  assign sub_write  = wr_q;
  assign rd_capture = rsp_take && !wr_q;
  assign completed  = compl_q;
  assign done_valid = done_q;
  assign done_id    = id_q;

endmodule

// File: rtl/dma_split_buf.sv
module dma_split_buf #(
  parameter int BLK_BYTES = 64,
  parameter int BUF_BYTES = 256,
  parameter int LEN_W     = 9,
  parameter int OFF_W     = 6,
  parameter int SUBLEN_W  = 7,
  parameter int IDX_W     = 8
) (
  input  logic                   clk,
  input  logic                   host_we,
  input  logic [IDX_W-1:0]       host_addr,
  input  logic [7:0]             host_data,
  input  logic [IDX_W-1:0]       rd_addr,
  output logic [7:0]             rd_data,
  input  logic [LEN_W-1:0]       completed,
  input  logic [OFF_W-1:0]       sub_off,
  input  logic [SUBLEN_W-1:0]    sub_len,
  input  logic                   capture,
  input  logic [BLK_BYTES*8-1:0] rsp_data,
  output logic [BLK_BYTES*8-1:0] sub_wdata,
  output logic [BLK_BYTES-1:0]   sub_be
);

  localparam int IW = LEN_W + 2;

  logic [7:0]           mem_q [BUF_BYTES];
  logic [BLK_BYTES-1:0] lane_en;
  logic [IDX_W-1:0]     lane_idx [BLK_BYTES];

  // each lane maps to one transfer-relative buffer byte
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    assign lane_en[g]  = (SUBLEN_W'(g) >= SUBLEN_W'(sub_off)) &&
                         (SUBLEN_W'(g) <  SUBLEN_W'(sub_off) + sub_len);
    assign lane_idx[g] = IDX_W'(IW'(completed) + IW'(g) - IW'(sub_off));
    assign sub_be[g]   = lane_en[g];
    assign sub_wdata[g*8 +: 8] = lane_en[g] ? mem_q[lane_idx[g]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (host_we) mem_q[host_addr] <= host_data;
    if (capture) begin
      for (int i = 0; i < BLK_BYTES; i++) begin
        if (lane_en[i]) mem_q[lane_idx[i]] <= rsp_data[i*8 +: 8];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dma_block_splitter.sv
module dma_block_splitter #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int BUF_BYTES = 256,
  parameter int ID_W      = 8,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1),
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int SUBLEN_W = OFF_W + 1,
  localparam int IDX_W    = $clog2(BUF_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   req_accept,
  output logic                   req_refuse,
  output logic [ID_W-1:0]        req_id,
  output logic                   busy,
  output logic                   sub_valid,
  input  logic                   sub_ready,
  output logic [ADDR_W-1:0]      sub_addr,
  output logic [OFF_W-1:0]       sub_off,
  output logic [SUBLEN_W-1:0]    sub_len,
  output logic                   sub_write,
  output logic [BLK_BYTES*8-1:0] sub_wdata,
  output logic [BLK_BYTES-1:0]   sub_be,
  input  logic                   rsp_valid,
  input  logic [BLK_BYTES*8-1:0] rsp_data,
  output logic                   done_valid,
  output logic [ID_W-1:0]        done_id,
  input  logic                   buf_we,
  input  logic [IDX_W-1:0]       buf_waddr,
  input  logic [7:0]             buf_wdata,
  input  logic [IDX_W-1:0]       buf_raddr,
  output logic [7:0]             buf_rdata
);

  logic             rst_sync_n;
  logic             rd_capture;
  logic [LEN_W-1:0] completed;

  dma_split_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_split_ctrl #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES),
    .BUF_BYTES (BUF_BYTES),
    .ID_W      (ID_W),
    .LEN_W     (LEN_W),
    .OFF_W     (OFF_W),
    .SUBLEN_W  (SUBLEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_accept (req_accept),
    .req_refuse (req_refuse),
    .req_id     (req_id),
    .busy       (busy),
    .sub_valid  (sub_valid),
    .sub_ready  (sub_ready),
    .sub_addr   (sub_addr),
    .sub_off    (sub_off),
    .sub_len    (sub_len),
    .sub_write  (sub_write),
    .rsp_valid  (rsp_valid),
    .rd_capture (rd_capture),
    .completed  (completed),
    .done_valid (done_valid),
    .done_id    (done_id)
  );

  dma_split_buf #(
    .BLK_BYTES (BLK_BYTES),
    .BUF_BYTES (BUF_BYTES),
    .LEN_W     (LEN_W),
    .OFF_W     (OFF_W),
    .SUBLEN_W  (SUBLEN_W),
    .IDX_W     (IDX_W)
  ) u_buf (
    .clk       (clk),
    .host_we   (buf_we),
    .host_addr (buf_waddr),
    .host_data (buf_wdata),
    .rd_addr   (buf_raddr),
    .rd_data   (buf_rdata),
    .completed (completed),
    .sub_off   (sub_off),
    .sub_len   (sub_len),
    .capture   (rd_capture),
    .rsp_data  (rsp_data),
    .sub_wdata (sub_wdata),
    .sub_be    (sub_be)
  );

endmodule

// File: rtl/dma_split_chk.sv
module dma_split_chk #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int ID_W      = 8,
  parameter int LEN_W     = 9,
  parameter int OFF_W     = 6,
  parameter int SUBLEN_W  = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [1:0]           req_kind,
  input logic [LEN_W-1:0]     req_len,
  input logic                 req_accept,
  input logic [ID_W-1:0]      req_id,
  input logic                 busy,
  input logic                 sub_valid,
  input logic                 sub_ready,
  input logic [ADDR_W-1:0]    sub_addr,
  input logic [OFF_W-1:0]     sub_off,
  input logic [SUBLEN_W-1:0]  sub_len,
  input logic                 sub_write,
  input logic [BLK_BYTES-1:0] sub_be,
  input logic                 done_valid
);

  AST_ACCEPT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (req_kind[1] == 1'b0) && (req_len != '0)); // R1
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |-> !req_accept); // R1
  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> req_id == ID_W'($past(req_id) + ID_W'(1))); // R2
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_accept |=> $stable(req_id)); // R2
  AST_OFF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> sub_addr[OFF_W-1:0] == sub_off); // R3
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (sub_len != '0) && (int'(sub_off) + int'(sub_len) <= BLK_BYTES)); // R4
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> sub_valid && $stable(sub_addr) && $stable(sub_len)); // R5
  AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_ready) |=> !sub_valid); // R5
  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_write) |-> $countones(sub_be) == int'(sub_len)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> busy); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sub_valid); // R10

endmodule

bind dma_block_splitter dma_split_chk #(
  .ADDR_W    (ADDR_W),
  .BLK_BYTES (BLK_BYTES),
  .ID_W      (ID_W),
  .LEN_W     (LEN_W),
  .OFF_W     (OFF_W),
  .SUBLEN_W  (SUBLEN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_len    (req_len),
  .req_accept (req_accept),
  .req_id     (req_id),
  .busy       (busy),
  .sub_valid  (sub_valid),
  .sub_ready  (sub_ready),
  .sub_addr   (sub_addr),
  .sub_off    (sub_off),
  .sub_len    (sub_len),
  .sub_write  (sub_write),
  .sub_be     (sub_be),
  .done_valid (done_valid)
);

// File: tb/dma_block_splitter_tb.sv
module dma_block_splitter_tb;

  localparam int ADDR_W = 16;
  localparam int BLK    = 8;
  localparam int BUFB   = 32;
  localparam int ID_W   = 4;
  localparam int LEN_W  = 6;
  localparam int OFF_W  = 3;
  localparam int SL_W   = 4;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_accept, req_refuse, busy;
  logic [1:0]        req_kind;
  logic [ADDR_W-1:0] req_addr, sub_addr;
  logic [LEN_W-1:0]  req_len;
  logic [ID_W-1:0]   req_id, done_id;
  logic              sub_valid, sub_ready, sub_write, rsp_valid, done_valid;
  logic [OFF_W-1:0]  sub_off;
  logic [SL_W-1:0]   sub_len;
  logic [BLK*8-1:0]  sub_wdata, rsp_data;
  logic [BLK-1:0]    sub_be;
  logic              buf_we;
  logic [IDX_W-1:0]  buf_waddr, buf_raddr;
  logic [7:0]        buf_wdata, buf_rdata;

  int checks = 0;
  int fails  = 0;
  int trn    = 0;
  int exp_id = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_block_splitter #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK), .BUF_BYTES(BUFB), .ID_W(ID_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
    .req_accept(req_accept), .req_refuse(req_refuse), .req_id(req_id), .busy(busy),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr), .sub_off(sub_off),
    .sub_len(sub_len), .sub_write(sub_write), .sub_wdata(sub_wdata), .sub_be(sub_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done_valid(done_valid), .done_id(done_id),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] memb(input int a);
    logic [15:0] x;
    x = 16'(a);
    return x[7:0] ^ (x[15:8] + 8'h3C);
  endfunction

  function automatic logic [7:0] wpat(input int k, input int t);
    return 8'(k * 5 + t * 3 + 1);
  endfunction

  task automatic bad_req(input logic [1:0] kind, input int len, input string rq);
    req_valid = 1'b1; req_kind = kind; req_addr = 16'h0040; req_len = LEN_W'(len);
    #1;
    chk(req_refuse && !req_accept, rq, int'(req_accept), 0);
    chk(int'(req_id) == exp_id, "R2 id kept on refusal", int'(req_id), exp_id);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_transfer(input int start, input int len, input bit wr,
                              input int dly, input bit stray, input bit poke);
    int  done;
    int  eoff, eaddr, elen;
    bit  first;
    bit  en;
    int  expb;
    if (wr) begin
      for (int k = 0; k < len; k++) begin
        buf_we = 1'b1; buf_waddr = IDX_W'(k); buf_wdata = wpat(k, trn);
        @(negedge clk);
      end
      buf_we = 1'b0;
    end
    req_valid = 1'b1; req_kind = wr ? 2'b01 : 2'b00;
    req_addr = 16'(start); req_len = LEN_W'(len);
    #1;
    chk(req_accept && !req_refuse, "R1 legal request accepted", int'(req_accept), 1);
    chk(int'(req_id) == exp_id, "R2 id on accept", int'(req_id), exp_id);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    if (poke) begin
      req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'h0000; req_len = 6'd4;
      #1;
      chk(req_refuse && !req_accept, "R1 refused while busy", int'(req_accept), 0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    done  = 0;
    first = 1'b1;
    while (1) begin
      eoff  = first ? (start % BLK) : 0;
      eaddr = (start + done) & 16'hFFFF;
      elen  = len - done;
      if (elen > BLK - eoff) elen = BLK - eoff;
      chk(sub_valid == 1'b1, "R5 piece offered", int'(sub_valid), 1);
      chk(int'(sub_addr) == eaddr, first ? "R3 first addr" : "R4 later addr", int'(sub_addr), eaddr);
      chk(int'(sub_off) == eoff, first ? "R3 first offset" : "R4 later offset", int'(sub_off), eoff);
      chk(int'(sub_len) == elen, first ? "R3 first length" : "R4 later length", int'(sub_len), elen);
      chk(sub_write == wr, "R1 direction", int'(sub_write), int'(wr));
      if (wr) begin
        for (int j = 0; j < BLK; j++) begin
          en   = (j >= eoff) && (j < eoff + elen);
          expb = en ? int'(wpat(done + j - eoff, trn)) : 0;
          chk(sub_be[j] == en, "R6 byte enable", int'(sub_be[j]), int'(en));
          chk(int'(sub_wdata[j*8 +: 8]) == expb, "R6 write lane", int'(sub_wdata[j*8 +: 8]), expb);
        end
      end
      for (int i = 0; i < dly; i++) begin
        if (stray && i == 0) begin
          rsp_valid = 1'b1; rsp_data = {BLK{8'hEE}};
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(sub_valid && int'(sub_addr) == eaddr, "R5 held until ready", int'(sub_addr), eaddr);
      end
      sub_ready = 1'b1;
      @(negedge clk);
      sub_ready = 1'b0;
      chk(sub_valid == 1'b0, "R5 one outstanding", int'(sub_valid), 0);
      if (dly > 0) begin
        @(negedge clk);
        chk(!sub_valid && !done_valid, "R5 waits for response", int'(sub_valid), 0);
      end
      rsp_valid = 1'b1;
      for (int j = 0; j < BLK; j++) rsp_data[j*8 +: 8] = memb(eaddr - eoff + j);
      @(negedge clk);
      rsp_valid = 1'b0;
      done = done + elen;
      if (done >= len) begin
        chk(done_valid == 1'b1, "R8 done pulse", int'(done_valid), 1);
        chk(int'(done_id) == exp_id, "R8 done id", int'(done_id), exp_id);
        chk(busy == 1'b0, "R8 busy cleared", int'(busy), 0);
        break;
      end
      first = 1'b0;
    end
    @(negedge clk);
    chk(done_valid == 1'b0, "R8 done one cycle", int'(done_valid), 0);
    chk(sub_valid == 1'b0, "R10 quiet when idle", int'(sub_valid), 0);
    if (!wr) begin
      for (int k = 0; k < len; k++) begin
        buf_raddr = IDX_W'(k);
        #1;
        chk(buf_rdata == memb(start + k), "R7 read packed", int'(buf_rdata), int'(memb(start + k)));
      end
      @(negedge clk);
    end
    exp_id = (exp_id + 1) % (1 << ID_W);
    trn++;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R5 watchdog actual=hung expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0; req_len = '0;
    sub_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    buf_we = 1'b0; buf_waddr = '0; buf_wdata = '0; buf_raddr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !sub_valid && !done_valid, "R9 reset state", int'(busy), 0);
    chk(req_id == '0, "R9 reset id", int'(req_id), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bad_req(2'b10, 4, "R1 fetch refused");
    bad_req(2'b11, 4, "R1 locked refused");
    bad_req(2'b00, 0, "R1 zero length refused");
    bad_req(2'b01, BUFB + 1, "R1 oversize refused");
    chk(!busy, "R1 idle after refusals", int'(busy), 0);
    for (int off = 0; off < BLK; off++) begin
      for (int len = 1; len <= 20; len++) begin
        for (int wr = 0; wr < 2; wr++) begin
          run_transfer(16'h0200 + (trn % 64) * 16 + off, len, wr[0],
                       trn % 3, (trn % 5) == 1, (trn % 7) == 3);
        end
      end
    end
    run_transfer(16'h7FF9, BUFB, 1'b1, 1, 1'b1, 1'b1);
    run_transfer(16'h7FF9, BUFB, 1'b0, 2, 1'b1, 1'b0);
    run_transfer(16'h1238, BUFB, 1'b0, 0, 1'b0, 1'b0);
    summary();
  end

endmodule